// File: doc/BRIEF.md
# Store-Multiple-Word Sequencer

This block carries out one store-multiple-word instruction for a core with 32 general registers of 64 bits and big-endian memory. It takes a 32-bit D-form instruction word and decodes it. It forms the effective address from a base register and a signed displacement. It then stores the low word of every register from the named start register up to register 31, one write per step, at ascending word addresses.

When reservation tracking is on and at least one reservation is live, the block first walks every 128-byte line that the whole transfer covers. It sends one invalidate request per line, and only then starts the stores. A misaligned effective address raises a fault pulse, and no store takes place. A one-cycle done pulse closes a completed transfer.

The instruction input, the invalidate channel and the write channel are all valid/ready. The instruction is taken only while the sequencer is idle. Back-pressure works the same way on both outbound channels: a stalled request keeps its valid and payload steady until ready is high at a clock edge, and the sequencer does not move on to the next line or register before that. The tracking flags and the done and fault pulses are plain signals. The register read port is combinational: the index is driven out and the data is expected back in the same cycle.

Top module: `multi_store_seq`

## Requirements
- R1: The primary opcode is instr_word[31:26], where instruction bit 0 is the MSB. Only the value 47 starts a transfer. The start register is in [25:21], the base register in [20:16] and the displacement in [15:0]. A word with any other opcode is taken while idle and produces no invalidate, no write, no done and no fault.
- R2: The effective address is the sign-extended displacement plus a base, modulo 2^32. The base is zero when the base register field is 0; otherwise it is the low 32 bits of that register.
- R3: A transfer from start register s issues exactly 32 − s writes. The write for register s+k goes to address EA + 4k, with the sum wrapping modulo 2^32, and the writes come in ascending register order.
- R4: wr_data is bits [31:0] of the register, and bits [63:32] have no effect. wr_data[31:24] is the byte for the lowest address wr_addr, and wr_data[7:0] is the byte for wr_addr+3.
- R5: If rsv_track_en and rsv_active are both high when the instruction is taken, the block sends one invalidate for each 128-byte line, in ascending order. The walk starts at the line holding EA and ends at the line holding EA + 4(32 − s) − 1, wrapping past address 0 if needed. A line address has its low 7 bits at zero. All invalidates come before the first write.
- R6: If either tracking flag is low when the instruction is taken, no invalidate is sent and the writes start at once.
- R7: If EA is not a multiple of 4, fault is high for exactly one cycle, the cycle after the instruction is taken, and no invalidate and no write follow.
- R8: A write or invalidate that is not accepted keeps its valid, address and data unchanged in the next cycle, and the register index does not advance until the write is accepted.
- R9: done is high for exactly the one cycle after the last write is accepted. instr_ready is high exactly when no transfer is in progress, including the cycle of the done pulse.
- R10: When the start register is 31, exactly one write is made.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Sequencer idle, takes the instruction |
| instr_word | input | 32 | D-form instruction word |
| rsv_track_en | input | 1 | Reservation tracking enabled |
| rsv_active | input | 1 | At least one reservation is live |
| rf_rd_idx | output | 5 | Register read index |
| rf_rd_data | input | 64 | Register contents for rf_rd_idx, same cycle |
| inv_valid | output | 1 | Line invalidate request valid |
| inv_ready | input | 1 | Invalidate request accepted |
| inv_line_addr | output | 32 | 128-byte aligned line address |
| wr_valid | output | 1 | Word write request valid |
| wr_ready | input | 1 | Word write accepted |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Word, most significant byte at wr_addr |
| done | output | 1 | One-cycle pulse after the final write |
| fault | output | 1 | One-cycle alignment fault pulse |

## Verification
The embedded properties watch, on every cycle, that stalled writes and invalidates hold steady and that the read index holds with them. They also check that line and word addresses stay aligned, that idle, invalidate and store never overlap, that done always follows an accepted write, and that a fault never appears alongside a request. The rest can only be shown by the bench's scenarios, compared against a behavioural model: the count of stores as a function of the start register, the address sequence and its wrap past zero, the selected data bits, the number and order of invalidated lines when the transfer crosses line boundaries, the skipped walk when either tracking flag is low, and the quiet handling of foreign opcodes.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INV   = 2'd1,
    ST_STORE = 2'd2
  } mst_state_e;

  localparam logic [5:0] OPC_STORE_MULTI = 6'd47;
  localparam int unsigned INSTR_W = 32;
endpackage

// File: rtl/mst_decode.sv
module mst_decode #(
  parameter int unsigned AW     = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic [31:0]       instr,
  input  logic [AW-1:0]     base_val,
  output logic              opc_hit,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] ra_idx,
  output logic [AW-1:0]     eff_addr
);
  import mst_pkg::*;

  localparam int unsigned DISP_W = 16;

  logic [DISP_W-1:0] disp;
  logic [AW-1:0]     disp_sx;
  logic [AW-1:0]     base_sel;

  // Fields counted from the MSB: opcode 0-5, source 6-10, base 11-15
  assign opc_hit  = (instr[31:26] == OPC_STORE_MULTI);
  assign rs_idx   = instr[25:21];
  assign ra_idx   = instr[20:16];
  assign disp     = instr[15:0];
  assign disp_sx  = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
  assign base_sel = (ra_idx == '0) ? '0 : base_val;
  assign eff_addr = base_sel + disp_sx;
endmodule

// File: rtl/mst_span.sv
module mst_span #(
  parameter int unsigned AW         = 32,
  parameter int unsigned RIDX_W     = 5,
  parameter int unsigned NREG       = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [AW-1:0]     eff_addr,
  input  logic [RIDX_W-1:0] rs_idx,
  output logic              misaligned,
  output logic [AW-1:0]     first_line,
  output logic [AW-1:0]     last_line
);
  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] WORD_MASK = AW'(WORD_BYTES - 1);
  localparam int unsigned   WB_LSB    = $clog2(WORD_BYTES);

  logic [AW-1:0] word_cnt;
  logic [AW-1:0] span_bytes;
  logic [AW-1:0] last_byte;

  assign misaligned = (eff_addr & WORD_MASK) != '0;
  assign word_cnt   = AW'(NREG) - AW'(rs_idx);
  assign span_bytes = word_cnt << WB_LSB;
  assign last_byte  = eff_addr + span_bytes - AW'(1);
  assign first_line = eff_addr & ~LINE_MASK;
  assign last_line  = last_byte & ~LINE_MASK;
endmodule

// File: rtl/multi_store_seq.sv
module multi_store_seq #(
  parameter int unsigned NREG       = 32,
  parameter int unsigned XLEN       = 64,
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      instr_valid,
  output logic                      instr_ready,
  input  logic [31:0]               instr_word,
  input  logic                      rsv_track_en,
  input  logic                      rsv_active,
  output logic [$clog2(NREG)-1:0]   rf_rd_idx,
  input  logic [XLEN-1:0]           rf_rd_data,
  output logic                      inv_valid,
  input  logic                      inv_ready,
  output logic [AW-1:0]             inv_line_addr,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [AW-1:0]             wr_addr,
  output logic [31:0]               wr_data,
  output logic                      done,
  output logic                      fault
);
  import mst_pkg::*;

  localparam int unsigned RIDX_W     = $clog2(NREG);
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned LINE_LSB   = $clog2(LINE_BYTES);
  localparam logic [RIDX_W-1:0] LAST_REG = RIDX_W'(NREG - 1);

  mst_state_e        state_q;
  logic [RIDX_W-1:0] cur_reg_q;
  logic [AW-1:0]     cur_addr_q;
  logic [AW-1:0]     line_cur_q;
  logic [AW-1:0]     line_end_q;
  logic              done_q;
  logic              fault_q;

  logic              opc_hit;
  logic [RIDX_W-1:0] rs_idx;
  logic [RIDX_W-1:0] ra_idx;
  logic [AW-1:0]     eff_addr;
  logic              misaligned;
  logic [AW-1:0]     first_line;
  logic [AW-1:0]     last_line;
  logic              take_instr;

  // Upper register half never reaches memory
  logic unused_hi;
  assign unused_hi = ^rf_rd_data[XLEN-1:WORD_W];

  mst_decode #(.AW(AW), .RIDX_W(RIDX_W)) u_decode (
    .instr    (instr_word),
    .base_val (rf_rd_data[AW-1:0]),
    .opc_hit  (opc_hit),
    .rs_idx   (rs_idx),
    .ra_idx   (ra_idx),
    .eff_addr (eff_addr)
  );

  mst_span #(
    .AW(AW), .RIDX_W(RIDX_W), .NREG(NREG),
    .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_span (
    .eff_addr   (eff_addr),
    .rs_idx     (rs_idx),
    .misaligned (misaligned),
    .first_line (first_line),
    .last_line  (last_line)
  );

  assign instr_ready   = (state_q == ST_IDLE);
  assign take_instr    = instr_valid && instr_ready;
  // One read port: base register while idle, store source while storing
  assign rf_rd_idx     = (state_q == ST_STORE) ? cur_reg_q : ra_idx;
  assign inv_valid     = (state_q == ST_INV);
  assign inv_line_addr = line_cur_q;
  assign wr_valid      = (state_q == ST_STORE);
  assign wr_addr       = cur_addr_q;
  assign wr_data       = rf_rd_data[WORD_W-1:0];
  assign done          = done_q;
  assign fault         = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_reg_q  <= '0;
      cur_addr_q <= '0;
      line_cur_q <= '0;
      line_end_q <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_instr && opc_hit) begin
            if (misaligned) begin
              fault_q <= 1'b1;
            end else begin
              cur_reg_q  <= rs_idx;
              cur_addr_q <= eff_addr;
              line_cur_q <= first_line;
              line_end_q <= last_line;
              state_q    <= (rsv_track_en && rsv_active) ? ST_INV : ST_STORE;
            end
          end
        end
        ST_INV: begin
          if (inv_ready) begin
            if (line_cur_q == line_end_q) begin
              state_q <= ST_STORE;
            end else begin
              line_cur_q <= line_cur_q + AW'(LINE_BYTES);
            end
          end
        end
        ST_STORE: begin
          if (wr_ready) begin
            if (cur_reg_q == LAST_REG) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cur_reg_q  <= cur_reg_q + RIDX_W'(1);
              cur_addr_q <= cur_addr_q + AW'(WORD_BYTES);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: stalled write keeps payload and register index
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                 && $stable(rf_rd_idx)));

  // R8: stalled invalidate keeps its line
  a_r8_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_line_addr)));

  // R5: invalidate, store and idle phases never overlap
  a_r5_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inv_valid, wr_valid, instr_ready}));

  // R5: line addresses carry no offset bits
  a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_line_addr[LINE_LSB-1:0] == '0));

  // R3: every write is word aligned
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  // R9: done follows an accepted write
  a_r9_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready));

  // R7: a fault comes with no request
  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!wr_valid && !inv_valid && !done));
endmodule

// File: tb/multi_store_seq_tb_top.sv
`timescale 1ns/100ps
module multi_store_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic        rsv_track_en = 1'b0;
  logic        rsv_active = 1'b0;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data;
  logic        inv_valid;
  logic        inv_ready = 1'b1;
  logic [31:0] inv_line_addr;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        done;
  logic        fault;

  logic [63:0] regs [32];
  assign rf_rd_data = regs[rf_rd_idx];

  always #2 clk = ~clk;

  multi_store_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .rsv_track_en(rsv_track_en), .rsv_active(rsv_active),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_line_addr(inv_line_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .fault(fault)
  );

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned cyc = 0;
  bit          running = 1'b0;
  bit          stall = 1'b0;

  logic [31:0] inv_q [$];
  logic [31:0] wa_q [$];
  logic [31:0] wd_q [$];
  bit          exp_done = 1'b0;
  bit          exp_fault = 1'b0;
  string       inv_tag = "R5";
  int unsigned n_wr_seen, n_inv_seen, n_fault_seen, exp_inv_n;
  logic [31:0] first_wr_addr;
  bit          prev_stall_wr = 1'b0;
  logic [31:0] prev_wa, prev_wd;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ea_of(input logic [31:0] w);
    logic [31:0] base;
    base = (w[20:16] == 5'd0) ? 32'd0 : regs[w[20:16]][31:0];
    return base + {{16{w[15]}}, w[15:0]};
  endfunction

  // Reference model: builds the expected request lists at instruction take
  task automatic model_take(input logic [31:0] w);
    logic [31:0] ea, last, ln, lend;
    int          s;
    if (w[31:26] != 6'd47) return;
    ea = ea_of(w);
    if (ea[1:0] != 2'b00) begin exp_fault = 1'b1; return; end
    s = int'(w[25:21]);
    if (rsv_track_en && rsv_active) begin
      inv_tag = "R5";
      last = ea + 32'((32 - s) * 4) - 32'd1;
      ln   = ea & ~32'd127;
      lend = last & ~32'd127;
      forever begin
        inv_q.push_back(ln);
        exp_inv_n++;
        if (ln == lend) break;
        ln = ln + 32'd128;
      end
    end else inv_tag = "R6";
    for (int r = s; r < 32; r++) begin
      wa_q.push_back(ea + 32'((r - s) * 4));
      wd_q.push_back(regs[r][31:0]);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      bit inv_pend, wr_pend;
      wr_ready  = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      inv_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      inv_pend = inv_q.size() > 0;
      wr_pend  = wa_q.size() > 0;
      if (done || exp_done) check(done == exp_done, "R9 done", done, exp_done);
      if (fault || exp_fault) check(fault == exp_fault, "R7 fault", fault, exp_fault);
      if (fault) n_fault_seen++;
      exp_done = 1'b0;
      exp_fault = 1'b0;
      check(instr_ready == (!inv_pend && !wr_pend), "R9 instr_ready", instr_ready,
            !inv_pend && !wr_pend);
      if (prev_stall_wr)
        check(wr_valid && wr_addr == prev_wa && wr_data == prev_wd, "R8 hold",
              {wr_addr, wr_data}, {prev_wa, prev_wd});
      if (inv_pend) begin
        check(inv_valid && inv_line_addr == inv_q[0], inv_tag, inv_line_addr, inv_q[0]);
        if (inv_valid && inv_ready) begin void'(inv_q.pop_front()); n_inv_seen++; end
      end else if (inv_valid) check(1'b0, inv_tag, inv_line_addr, 0);
      if (!inv_pend && wr_pend) begin
        check(wr_valid && wr_addr == wa_q[0], "R3 addr", wr_addr, wa_q[0]);
        check(wr_data == wd_q[0], "R4 data", wr_data, wd_q[0]);
        if (wr_valid && wr_ready) begin
          if (n_wr_seen == 0) first_wr_addr = wr_addr;
          n_wr_seen++;
          void'(wa_q.pop_front());
          void'(wd_q.pop_front());
          if (wa_q.size() == 0) exp_done = 1'b1;
        end
      end else if (wr_valid) check(1'b0, "R3 early write", wr_addr, 0);
      prev_stall_wr = wr_valid && !wr_ready;
      prev_wa = wr_addr;
      prev_wd = wr_data;
      if (instr_valid && instr_ready) model_take(instr_word);
    end
  end

  task automatic run_instr(input logic [31:0] w, input bit trk, input bit act,
                           input string tag);
    int unsigned exp_n;
    logic [31:0] ea;
    ea = ea_of(w);
    exp_n = (w[31:26] == 6'd47 && ea[1:0] == 2'b00) ? 32 - int'(w[25:21]) : 0;
    n_wr_seen = 0; n_inv_seen = 0; n_fault_seen = 0; exp_inv_n = 0;
    @(negedge clk);
    rsv_track_en = trk;
    rsv_active   = act;
    instr_word   = w;
    instr_valid  = 1'b1;
    #1.5;
    while (!instr_ready) begin @(negedge clk); #1.5; end
    @(negedge clk);
    instr_valid = 1'b0;
    #1.5;
    while (inv_q.size() != 0 || wa_q.size() != 0 || exp_done || exp_fault) begin
      @(negedge clk); #1.5;
    end
    repeat (2) @(negedge clk);
    check(n_wr_seen == exp_n, {tag, " write count"}, n_wr_seen, exp_n);
    check(n_inv_seen == exp_inv_n, {tag, " invalidate count"}, n_inv_seen, exp_inv_n);
    if (exp_n > 0) check(first_wr_addr == ea, "R2 first address", first_wr_addr, ea);
  endtask

  function automatic logic [31:0] enc(input int opc, input int rs, input int ra,
                                      input logic [15:0] d);
    return {6'(opc), 5'(rs), 5'(ra), d};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++)
      regs[r] = {32'hA5A5_0000 | 32'(r), 32'h1000_0000 + 32'(r * 32'h0101_0101)};
    regs[5] = 64'hDEAD_BEEF_0000_2000;
    regs[7] = 64'h0000_0001_FFFF_FFF0;
    regs[9] = 64'h0000_0000_0000_01F0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(instr_ready && !wr_valid && !inv_valid && !done && !fault, "R9 reset state",
          {instr_ready, wr_valid, inv_valid, done, fault}, 5'b10000);
    running = 1'b1;
    // R10: single store, zero base
    run_instr(enc(47, 31, 0, 16'h0100), 1'b0, 1'b0, "R10");
    // R2/R5: base register with high half set, negative displacement
    run_instr(enc(47, 20, 5, 16'hFFF8), 1'b1, 1'b1, "R5");
    // R5: full 32-word transfer crossing a line boundary
    run_instr(enc(47, 0, 9, 16'h0000), 1'b1, 1'b1, "R5 cross");
    // R6: tracking on but no live reservation
    run_instr(enc(47, 0, 9, 16'h0000), 1'b1, 1'b0, "R6 inactive");
    // R6: tracking off
    run_instr(enc(47, 16, 0, 16'h0400), 1'b0, 1'b1, "R6 off");
    // R7: misaligned address
    run_instr(enc(47, 4, 0, 16'h0002), 1'b1, 1'b1, "R7");
    check(n_fault_seen == 1, "R7 fault count", n_fault_seen, 1);
    // R1: foreign opcode produces nothing
    run_instr(enc(46, 4, 0, 16'h0000), 1'b1, 1'b1, "R1");
    check(n_fault_seen == 0, "R1 no fault", n_fault_seen, 0);
    // R3: address wrap past zero, line walk wraps too
    run_instr(enc(47, 24, 7, 16'h0000), 1'b1, 1'b1, "R3 wrap");
    // R8: random back-pressure on both channels
    stall = 1'b1;
    run_instr(enc(47, 8, 9, 16'h0070), 1'b1, 1'b1, "R8 stall");
    run_instr(enc(47, 29, 0, 16'h7FFC), 1'b0, 1'b0, "R8 stall short");
    stall = 1'b0;
    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule